// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer that software arms and services through writes of a single 32-bit control word. Each write carries a 7-bit key, a run/stop command bit and a count field. While the watchdog is armed, only a write whose key is the bitwise inverse of the key from the last accepted write gets through. A stray write, or a runaway loop that keeps writing one value, therefore cannot keep the watchdog alive.

The down-counter advances only on cycles where the slow tick enable input is high. That input is a single-cycle strobe at a rate of roughly 760 Hz, produced outside the block. Expiry happens in two stages. When the count first runs out, the block raises a non-maskable interrupt and reloads a short grace count. If the grace count also runs out before software services the watchdog, the block issues a one-cycle system reset request and stops counting.

Any accepted write clears the interrupt and returns the block to the first stage. Turning the reset request into an actual reset is left to logic outside the block.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset the stored control word is 0, the watchdog is stopped (disarmed) and the count is 0. The NMI output and the reset request are both low.
- R2: While bit 8 of the stored control word is 0, every write is accepted, whatever its key.
- R3: While bit 8 of the stored control word is 1, a write is accepted only if bits [15:9] of the written word equal the 7-bit inverse of bits [15:9] of the stored word. A rejected write leaves the control word, the count, the run state and the NMI output unchanged.
- R4: An accepted write does three things. It stores the whole written word. It loads the counter from bits [7:0] of that word. It sets the run state to bit 8 of that word, so 1 runs the counter and 0 stops it.
- R5: A count field of zero loads 256.
- R6: While running, each cycle with the tick input high lowers the count by one. While stopped, the count does not change.
- R7: A tick that arrives while the count is 1 is an expiry. On the first expiry the NMI output goes high, the count is reloaded with the grace count (parameter, default 1) and the counter keeps running.
- R8: An expiry while the NMI output is already high raises the reset request and stops the counter. The count is left at 0.
- R9: An accepted write lowers the NMI output and returns the block to the first expiry stage.
- R10: When an accepted write and a tick arrive in the same cycle, the write wins and the tick is lost.
- R11: The reset request is high for exactly one clock cycle for each final expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Single-cycle slow tick strobe |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: key [15:9], run bit 8, count [7:0] |
| ctrl_o | output | 32 | Stored control word |
| count_o | output | 9 | Current counter value |
| running_o | output | 1 | Counter run state |
| nmi_o | output | 1 | Non-maskable interrupt, first expiry stage |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest condition to reach from the ports is the final expiry. Getting there needs an armed counter and a run of ticks with no accepted write for the whole main count and then for the whole grace count. A rejected write must also be placed between them, to show that it does not restart the chain. A directed sequence sets up exactly this chain with a small count. It then checks the collision of a write and a tick in the same cycle. After that, a long random phase mixes correct keys, wrong keys and dense ticks, so the reset request comes up several times, and a reference model in the bench follows every cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic {
    STAGE_ARMED  = 1'b0,
    STAGE_WARNED = 1'b1
  } wdg_stage_e;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 7,
  parameter int KEY_LSB = 9,
  parameter int CMD_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              accept
);
  localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

  logic [KEY_W-1:0] bit_inv;
  logic             armed;

  // Each key bit must differ from the stored one
  for (genvar i = 0; i < KEY_W; i++) begin : g_key
    assign bit_inv[i] = wr_data[KEY_LSB+i] ^ ctrl_q[KEY_LSB+i];
  end

  assign armed  = ctrl_q[CMD_BIT];
  assign accept = wr_en && (!armed || (&bit_inv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (accept) ctrl_q <= wr_data;
  end

  // R3: a locked write with a wrong key leaves the word alone
  p_wrong_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && armed && (wr_data[KEY_MSB:KEY_LSB] != ~ctrl_q[KEY_MSB:KEY_LSB]))
    |=> $stable(ctrl_q));

  // R4: an accepted word is stored whole
  p_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ctrl_q == $past(wr_data));
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
  parameter int CNT_FLD_W   = 8,
  parameter int GRACE_TICKS = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [CNT_FLD_W-1:0] load_fld,
  input  logic                 load_cmd,
  input  logic                 tick_en,
  input  logic                 warned,
  output logic [CNT_FLD_W:0]   cnt_q,
  output logic                 run_q,
  output logic                 expire
);
  localparam int CNT_W = CNT_FLD_W + 1;
  localparam logic [CNT_W-1:0] ZERO_LOAD  = CNT_W'(1) << CNT_FLD_W;
  localparam logic [CNT_W-1:0] GRACE_LOAD = CNT_W'(GRACE_TICKS);

  logic [CNT_W-1:0] load_val;
  logic             step;

  assign load_val = (load_fld == '0) ? ZERO_LOAD : {1'b0, load_fld};
  assign step     = run_q && tick_en && !accept;
  assign expire   = step && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (accept) begin
      cnt_q <= load_val;
      run_q <= load_cmd;
    end else if (expire) begin
      if (warned) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= GRACE_LOAD;
      end
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R6: one step per tick while running
  p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && !accept && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R6: a stopped counter holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !accept) |=> $stable(cnt_q) && !run_q);

  // R5 and R4: reload from the written field, zero meaning full range
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && load_fld == '0) |=> cnt_q == ZERO_LOAD);

  // R10: a write in a tick cycle loads, without a decrement
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tick_en) |=> cnt_q == $past(load_val));
endmodule

// File: rtl/wdg_expiry_stage.sv
module wdg_expiry_stage
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic expire,
  output logic warned,
  output logic reset_req
);
  wdg_stage_e stage_q;

  assign warned = (stage_q == STAGE_WARNED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= STAGE_ARMED;
      reset_req <= 1'b0;
    end else begin
      reset_req <= expire && warned;
      if (accept)      stage_q <= STAGE_ARMED;
      else if (expire) stage_q <= STAGE_WARNED;
    end
  end

  // R11: the reset request never lasts two cycles
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R8: the reset request comes only out of the warned stage
  p_reset_after_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> warned);

  // R9: an accepted write clears the interrupt
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !warned);
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top #(
  parameter int DATA_W      = 32,
  parameter int KEY_W       = 7,
  parameter int KEY_LSB     = 9,
  parameter int CMD_BIT     = 8,
  parameter int CNT_FLD_W   = 8,
  parameter int GRACE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [CNT_FLD_W:0] count_o,
  output logic              running_o,
  output logic              nmi_o,
  output logic              reset_req_o
);
  logic accept;
  logic expire;
  logic warned;

  wdg_key_gate #(
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W),
    .KEY_LSB(KEY_LSB),
    .CMD_BIT(CMD_BIT)
  ) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .ctrl_q (ctrl_o),
    .accept (accept)
  );

  wdg_down_counter #(
    .CNT_FLD_W  (CNT_FLD_W),
    .GRACE_TICKS(GRACE_TICKS)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .load_fld(wr_data[CNT_FLD_W-1:0]),
    .load_cmd(wr_data[CMD_BIT]),
    .tick_en (tick_en),
    .warned  (warned),
    .cnt_q   (count_o),
    .run_q   (running_o),
    .expire  (expire)
  );

  wdg_expiry_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .expire   (expire),
    .warned   (warned),
    .reset_req(reset_req_o)
  );

  assign nmi_o = warned;

  // R7: entering the warned stage leaves the grace count running
  p_nmi_grace_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> (running_o && count_o == (CNT_FLD_W+1)'(GRACE_TICKS)));

  // R8: the final expiry stops the counter
  p_reset_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> (!running_o && count_o == '0));
endmodule

// File: tb/wdg_keyed_top_test.sv
module wdg_keyed_top_test;
  localparam int GRACE = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_o;
  logic [8:0]  count_o;
  logic        running_o, nmi_o, reset_req_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_ctrl = '0;
  int          m_cnt = 0;
  bit          m_run = 0, m_nmi = 0, m_rst = 0;

  always #2.5 clk = ~clk;

  wdg_keyed_top uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .ctrl_o(ctrl_o), .count_o(count_o),
    .running_o(running_o), .nmi_o(nmi_o), .reset_req_o(reset_req_o)
  );

  function automatic logic [31:0] mk(input logic [6:0] key, input bit cmd, input logic [7:0] cnt);
    return {16'h0, key, cmd, cnt};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      m_ctrl = '0; m_cnt = 0; m_run = 0; m_nmi = 0; m_rst = 0;
    end else begin
      acc = wr_en && (!m_ctrl[8] || (wr_data[15:9] == ~m_ctrl[15:9]));
      m_rst = 0;
      if (acc) begin
        m_ctrl = wr_data;
        m_cnt  = (wr_data[7:0] == 0) ? 256 : int'(wr_data[7:0]);
        m_run  = wr_data[8];
        m_nmi  = 0;
      end else if (m_run && tick_en) begin
        if (m_cnt <= 1) begin
          if (!m_nmi) begin m_nmi = 1; m_cnt = GRACE; end
          else begin m_rst = 1; m_run = 0; m_cnt = 0; end
        end else m_cnt--;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ctrl_o == m_ctrl, "R3 R4 model ctrl", ctrl_o, m_ctrl);
      check(int'(count_o) == m_cnt, "R6 model count", count_o, m_cnt);
      check(running_o == m_run, "R4 model run", running_o, m_run);
      check(nmi_o == m_nmi, "R7 model nmi", nmi_o, m_nmi);
      check(reset_req_o == m_rst, "R8 model reset", reset_req_o, m_rst);
    end
  end

  task automatic step(input bit we, input logic [31:0] d, input bit tk);
    wr_en = we; wr_data = d; tick_en = tk;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(ctrl_o == 0 && count_o == 0 && !running_o, "R1 idle", {ctrl_o, count_o}, 0);
    check(!nmi_o && !reset_req_o, "R1 outputs", {nmi_o, reset_req_o}, 0);

    step(1, mk(7'h15, 0, 8'd5), 0);
    check(ctrl_o == mk(7'h15, 0, 8'd5), "R2 disabled write stored", ctrl_o, mk(7'h15, 0, 8'd5));
    check(count_o == 5 && !running_o, "R4 load stopped", count_o, 5);
    repeat (3) step(0, '0, 1);
    check(count_o == 5, "R6 stopped holds", count_o, 5);

    step(1, mk(7'h33, 1, 8'd3), 0);
    check(count_o == 3 && running_o, "R2 any key while disarmed", count_o, 3);
    step(1, mk(7'h33, 1, 8'd9), 0);
    check(ctrl_o == mk(7'h33, 1, 8'd3), "R3 wrong key ignored ctrl", ctrl_o, mk(7'h33, 1, 8'd3));
    check(count_o == 3, "R3 wrong key ignored count", count_o, 3);
    step(0, '0, 1);
    check(count_o == 2, "R6 decrement", count_o, 2);
    step(0, '0, 1);
    step(0, '0, 1);
    check(nmi_o && running_o && count_o == GRACE, "R7 first expiry", {nmi_o, count_o}, {1'b1, 9'(GRACE)});
    step(0, '0, 1);
    check(reset_req_o && !running_o, "R8 final expiry", reset_req_o, 1);
    step(0, '0, 0);
    check(!reset_req_o && nmi_o, "R11 single pulse", reset_req_o, 0);

    step(1, mk(7'h4C, 1, 8'd0), 0);
    check(!nmi_o, "R9 write clears nmi", nmi_o, 0);
    check(count_o == 256 && running_o, "R5 zero loads 256", count_o, 256);
    step(1, mk(7'h33, 1, 8'd4), 1);
    check(count_o == 4, "R10 write beats tick", count_o, 4);
    step(1, mk(7'h4C, 0, 8'd7), 0);
    check(!running_o && count_o == 7, "R4 stop command", count_o, 7);
    step(1, mk(7'h12, 1, 8'd2), 0);
    check(count_o == 2 && running_o, "R2 disarmed after stop", count_o, 2);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [6:0]  k;
      bit we, tk;
      we = ($urandom % 8) == 0;
      tk = ($urandom % 3) == 0;
      k  = ($urandom % 2 == 0) ? ~m_ctrl[15:9] : 7'($urandom);
      d  = {16'($urandom), k, 1'(($urandom % 4) != 0), 8'($urandom % 6)};
      step(we, d, tk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule